// File: doc/BRIEF.md
# Entropy Source Start-up Sequencer with Health Tests

This block governs how a true random number generator comes out of reset, enable or a deep-sleep wake-up. The noise source runs freely and asynchronously, and one sampled bit per clock arrives on `noise_bit_i`. The block does not hand out any random word until a fixed, ordered pipeline has finished. That pipeline has four steps:

1. A programmable settling wait.
2. A health-test window. A repetition-run test and a proportion test watch the same bit stream at the same time.
3. A whitening pass. It can be skipped.
4. A pre-fill of the output word queue.

The whitening stage here is a stand-in shift-register mixer. It has the required latency but no cryptographic strength. Dropping the enable discards all progress, and the next enable starts again from the settling wait. A health-test failure raises a sticky cause flag and runs the test window again from its start. No word is released until a clean pass of the whole sequence completes.

Software or a wrapper drives the block with its enable and a small configuration: settling length, whitening bypass, and the two test cutoffs. Once the sequencer reports its ready phase, the wrapper reads words through a show-ahead port. With default parameters a clean start-up takes 256 + 4096 + 128 + 2048 = 6528 clocks. A build with a 1024-clock settling wait takes 7296 clocks.

Top module: `trng_startup_seq`

## Requirements
- R1: During and after reset the phase output is idle (0), the read-valid flag is 0 and both error bits are 0. The phase encoding is idle=0, settle=1, test=2, whiten=3, fill=4, ready=5, and no other value ever appears. With the enable low the phase stays idle.
- R2: When the enable is high in the idle phase, the settle phase (1) begins on the next clock. It lasts exactly L clocks, where L is taken from `warm_cfg_i` when settle starts:
  - a value of 0 selects WARM_DEF;
  - a value above WARM_MAX is clamped to WARM_MAX;
  - any other value is used as given.
- R3: The test phase (2) follows settle and lasts exactly APT_WIN clocks when no test fails. Noise bits are only examined during this phase.
- R4: With `cond_bypass_i` = 0 at the last test clock, a whiten phase (3) of exactly COND_CYC clocks follows. With it at 1, the whiten phase is skipped and fill follows test directly.
- R5: The fill phase (4) lasts exactly FIFO_DEPTH*WORD_W clocks. Ready (5) follows, and on the first ready clock the read-valid flag is 1 with FIFO_DEPTH words queued. The read-valid flag is only ever 1 in the ready phase.
- R6: The repetition test counts a run of identical samples. It fails on the sample where the run length exceeds `rct_cutoff_i`. The first sample of every block of RCT_WIN consecutive test samples begins a new run of length 1.
- R7: The proportion test takes the first sample of the test window as reference. It fails on the sample where the count of reference-valued samples, including the first, exceeds `apt_cutoff_i`.
- R8: A failure has three effects on the next clock:
  - it sets `health_err_o` bit 0 (repetition test) or bit 1 (proportion test);
  - the phase stays test;
  - the test window starts again with its full length.
  Error bits stay set until reset, including across disable.
- R9: With the enable low, the next clock shows idle with read-valid 0 and the queue emptied, from any phase. A new enable replays the whole sequence from settle.
- R10: In bypass mode each queued word holds WORD_W consecutive fill-phase noise bits. The earliest bit is at the most significant position.
- R11: With whitening on, a mixer state s of MIX_W bits is cleared outside the whiten, fill and ready phases. On each such clock the mixer computes o = noise ^ s[MIX_W-1] ^ s[MIX_TAP] and then shifts s left with o entering at bit 0. The fill-phase o bits are packed into words as in R10.
- R12: The read port is show-ahead. `rd_data_o` holds the oldest word while read-valid is 1, and `rd_en_i` with read-valid removes it at the clock edge. In ready, new words keep being packed and queued whenever there is room, so read-valid returns after the queue is drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| enable_i | input | 1 | Run enable; low clears all progress |
| noise_bit_i | input | 1 | One sampled noise bit per clock |
| cond_bypass_i | input | 1 | 1 skips the whitening phase |
| warm_cfg_i | input | $clog2(WARM_MAX+1) | Settle length request |
| rct_cutoff_i | input | $clog2(RCT_WIN+1) | Longest allowed repetition run |
| apt_cutoff_i | input | $clog2(APT_WIN+1) | Largest allowed reference count per window |
| rd_en_i | input | 1 | Pop the head word |
| rd_data_o | output | WORD_W | Head word of the queue |
| rd_valid_o | output | 1 | Head word available (ready phase only) |
| phase_o | output | 3 | Current phase code |
| health_err_o | output | 2 | Sticky failure causes: bit 0 repetition, bit 1 proportion |

## Verification
A miscounted phase counter appears at once as a phase code held one clock too long or too short. Measuring every phase length at the phase port pins that fault down to the exact clock. A wrong run or reference count in the tests appears as an error bit rising one clock early or late, relative to the sample index the rules predict. Wrong packing, mixer taps or queue pointers are invisible until ready. At that point the first read returns a word that differs from the one computed from the logged fill-phase bits. A missed flush on disable appears on the next clock as read-valid staying high outside ready.

// File: rtl/trng_seq_pkg.sv
package trng_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_WARM  = 3'd1,
      PH_TEST  = 3'd2,
      PH_COND  = 3'd3,
      PH_FILL  = 3'd4,
      PH_READY = 3'd5
   } phase_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/trng_phase_ctrl.sv
module trng_phase_ctrl
   import trng_seq_pkg::*;
#(
   parameter int WARM_MAX = 256,
   parameter int WARM_DEF = 256,
   parameter int TEST_CYC = 4096,
   parameter int COND_CYC = 128,
   parameter int FILL_CYC = 2048,
   parameter int CFG_W    = $clog2(WARM_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  logic [CFG_W-1:0] warm_cfg_i,
   input  logic             bypass_i,
   input  logic             fail_i,
   output phase_e           phase_o,
   output logic             cond_on_o
);

   localparam int LONGEST = max2(max2(WARM_MAX, TEST_CYC), max2(COND_CYC, FILL_CYC));
   localparam int CNT_W   = $clog2(LONGEST + 1);

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] warm_len_q;
   logic [CNT_W-1:0] warm_len_d;
   logic [CNT_W-1:0] cur_len;
   logic             phase_done;
   logic             byp_q;

   // settle length: 0 picks the default, oversize requests are clamped
   always_comb begin
      if (warm_cfg_i == '0)
         warm_len_d = CNT_W'(WARM_DEF);
      else if (warm_cfg_i > CFG_W'(WARM_MAX))
         warm_len_d = CNT_W'(WARM_MAX);
      else
         warm_len_d = CNT_W'(warm_cfg_i);
   end

   always_comb begin
      unique case (phase_q)
         PH_WARM: cur_len = warm_len_q;
         PH_TEST: cur_len = CNT_W'(TEST_CYC);
         PH_COND: cur_len = CNT_W'(COND_CYC);
         default: cur_len = CNT_W'(FILL_CYC);
      endcase
   end

   assign phase_done = (cnt_q == cur_len - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         cnt_q      <= '0;
         warm_len_q <= '0;
         byp_q      <= 1'b0;
      end else if (!enable_i) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               phase_q    <= PH_WARM;
               cnt_q      <= '0;
               warm_len_q <= warm_len_d;
            end
            PH_WARM: begin
               if (phase_done) begin
                  phase_q <= PH_TEST;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_TEST: begin
               if (fail_i) begin
                  cnt_q <= '0;
               end else if (phase_done) begin
                  byp_q   <= bypass_i;
                  cnt_q   <= '0;
                  phase_q <= bypass_i ? PH_FILL : PH_COND;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_COND: begin
               if (phase_done) begin
                  phase_q <= PH_FILL;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_FILL: begin
               if (phase_done) begin
                  phase_q <= PH_READY;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: phase_q <= PH_READY;
         endcase
      end
   end

   assign phase_o   = phase_q;
   assign cond_on_o = ~byp_q;

endmodule

// File: rtl/trng_health.sv
module trng_health
   import trng_seq_pkg::*;
#(
   parameter int RCT_WIN = 64,
   parameter int APT_WIN = 4096,
   parameter int RCUT_W  = $clog2(RCT_WIN + 1),
   parameter int ACUT_W  = $clog2(APT_WIN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_i,
   input  logic              bit_i,
   input  logic [RCUT_W-1:0] rct_cut_i,
   input  logic [ACUT_W-1:0] apt_cut_i,
   output logic              rct_fail_o,
   output logic              apt_fail_o
);

   localparam int RIDX_W = $clog2(RCT_WIN);

   logic [RIDX_W-1:0] ridx_q;
   logic [RIDX_W-1:0] ridx_nxt;
   logic [RCUT_W-1:0] run_q;
   logic [RCUT_W-1:0] run_nxt;
   logic              last_q;
   logic              afirst_q;
   logic              aref_q;
   logic [ACUT_W-1:0] acnt_q;
   logic [ACUT_W-1:0] acnt_nxt;
   logic              any_fail;

   // window index wrap: free-running for power-of-two windows
   generate
      if (is_pow2(RCT_WIN)) begin : g_ridx_pow2
         assign ridx_nxt = ridx_q + 1'b1;
      end else begin : g_ridx_cmp
         assign ridx_nxt = (ridx_q == RIDX_W'(RCT_WIN - 1)) ? '0 : ridx_q + 1'b1;
      end
   endgenerate

   always_comb begin
      if (ridx_q == '0)
         run_nxt = RCUT_W'(1);
      else if (bit_i == last_q)
         run_nxt = run_q + 1'b1;
      else
         run_nxt = RCUT_W'(1);
   end

   always_comb begin
      if (afirst_q)
         acnt_nxt = ACUT_W'(1);
      else if (bit_i == aref_q)
         acnt_nxt = acnt_q + 1'b1;
      else
         acnt_nxt = acnt_q;
   end

   assign rct_fail_o = active_i && (run_nxt > rct_cut_i);
   assign apt_fail_o = active_i && (acnt_nxt > apt_cut_i);
   assign any_fail   = rct_fail_o | apt_fail_o;

   always_ff @(posedge clk) begin
      if (!rst_n || !active_i || any_fail) begin
         ridx_q   <= '0;
         run_q    <= '0;
         last_q   <= 1'b0;
         afirst_q <= 1'b1;
         aref_q   <= 1'b0;
         acnt_q   <= '0;
      end else begin
         ridx_q   <= ridx_nxt;
         run_q    <= run_nxt;
         last_q   <= bit_i;
         afirst_q <= 1'b0;
         acnt_q   <= acnt_nxt;
         if (afirst_q)
            aref_q <= bit_i;
      end
   end

endmodule

// File: rtl/trng_mixer.sv
module trng_mixer #(
   parameter int MIX_W   = 32,
   parameter int MIX_TAP = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic bit_i,
   output logic mix_bit_o
);

   logic [MIX_W-1:0] st_q;

   assign mix_bit_o = bit_i ^ st_q[MIX_W-1] ^ st_q[MIX_TAP];

   always_ff @(posedge clk) begin
      if (!rst_n || !run_i)
         st_q <= '0;
      else
         st_q <= {st_q[MIX_W-2:0], mix_bit_o};
   end

endmodule

// File: rtl/trng_word_fifo.sv
module trng_word_fifo
   import trng_seq_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              bit_vld_i,
   input  logic              bit_i,
   input  logic              pop_i,
   output logic [WORD_W-1:0] rd_data_o,
   output logic              empty_o
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int BC_W  = $clog2(WORD_W);

   logic [WORD_W-2:0] sh_q;
   logic [BC_W-1:0]   bcnt_q;
   logic [WORD_W-1:0] word_d;
   logic              word_done;
   logic              push;
   logic              pop_ok;
   logic              full;
   logic [PTR_W-1:0]  wr_q;
   logic [PTR_W-1:0]  rd_q;
   logic [PTR_W-1:0]  wr_nxt;
   logic [PTR_W-1:0]  rd_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] mem_q [DEPTH];

   generate
      if (is_pow2(DEPTH)) begin : g_ptr_pow2
         assign wr_nxt = wr_q + 1'b1;
         assign rd_nxt = rd_q + 1'b1;
      end else begin : g_ptr_cmp
         assign wr_nxt = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_nxt = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   assign word_d    = {sh_q, bit_i};
   assign word_done = bit_vld_i && (bcnt_q == BC_W'(WORD_W - 1));
   assign empty_o   = (cnt_q == '0);
   assign full      = (cnt_q == CNT_W'(DEPTH));
   assign pop_ok    = pop_i && !empty_o;
   assign push      = word_done && (!full || pop_ok);
   assign rd_data_o = mem_q[rd_q];

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         sh_q   <= '0;
         bcnt_q <= '0;
         wr_q   <= '0;
         rd_q   <= '0;
         cnt_q  <= '0;
      end else begin
         if (bit_vld_i) begin
            sh_q   <= word_d[WORD_W-2:0];
            bcnt_q <= word_done ? '0 : bcnt_q + 1'b1;
         end
         if (push)
            wr_q <= wr_nxt;
         if (pop_ok)
            rd_q <= rd_nxt;
         if (push && !pop_ok)
            cnt_q <= cnt_q + 1'b1;
         else if (pop_ok && !push)
            cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push)
         mem_q[wr_q] <= word_d;
   end

endmodule

// File: rtl/trng_startup_seq.sv
module trng_startup_seq
   import trng_seq_pkg::*;
#(
   parameter int WARM_MAX   = 256,
   parameter int WARM_DEF   = 256,
   parameter int RCT_WIN    = 64,
   parameter int APT_WIN    = 4096,
   parameter int COND_CYC   = 128,
   parameter int FIFO_DEPTH = 64,
   parameter int WORD_W     = 32,
   parameter int MIX_W      = 32,
   parameter int MIX_TAP    = 13,
   localparam int WCFG_W    = $clog2(WARM_MAX + 1),
   localparam int RCUT_W    = $clog2(RCT_WIN + 1),
   localparam int ACUT_W    = $clog2(APT_WIN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              noise_bit_i,
   input  logic              cond_bypass_i,
   input  logic [WCFG_W-1:0] warm_cfg_i,
   input  logic [RCUT_W-1:0] rct_cutoff_i,
   input  logic [ACUT_W-1:0] apt_cutoff_i,
   input  logic              rd_en_i,
   output logic [WORD_W-1:0] rd_data_o,
   output logic              rd_valid_o,
   output logic [2:0]        phase_o,
   output logic [1:0]        health_err_o
);

   localparam int FILL_CYC = FIFO_DEPTH * WORD_W;

   // elaboration-time parameter checks
   generate
      if (WARM_DEF < 1 || WARM_DEF > WARM_MAX) begin : g_bad_warm
         $error("settle default must lie in 1..WARM_MAX");
      end
      if (RCT_WIN < 2 || RCT_WIN > APT_WIN) begin : g_bad_rct
         $error("repetition window must lie in 2..APT_WIN");
      end
      if (COND_CYC < 1 || FIFO_DEPTH < 1) begin : g_bad_len
         $error("whiten length and queue depth must be positive");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("word width must be at least 2");
      end
      if (MIX_W < 2 || MIX_TAP < 0 || MIX_TAP >= MIX_W - 1) begin : g_bad_mix
         $error("mixer tap must lie below the top state bit");
      end
   endgenerate

   phase_e phase;
   logic   cond_on;
   logic   rct_fail;
   logic   apt_fail;
   logic   in_test;
   logic   collecting;
   logic   mix_run;
   logic   mix_bit;
   logic   fifo_bit;
   logic   fifo_empty;
   logic   pop;
   logic [1:0] err_q;

   assign in_test    = (phase == PH_TEST);
   assign collecting = (phase == PH_FILL) || (phase == PH_READY);
   assign mix_run    = cond_on && ((phase == PH_COND) || collecting);
   assign fifo_bit   = cond_on ? mix_bit : noise_bit_i;

   trng_phase_ctrl #(
      .WARM_MAX (WARM_MAX),
      .WARM_DEF (WARM_DEF),
      .TEST_CYC (APT_WIN),
      .COND_CYC (COND_CYC),
      .FILL_CYC (FILL_CYC),
      .CFG_W    (WCFG_W)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable_i   (enable_i),
      .warm_cfg_i (warm_cfg_i),
      .bypass_i   (cond_bypass_i),
      .fail_i     (rct_fail | apt_fail),
      .phase_o    (phase),
      .cond_on_o  (cond_on)
   );

   trng_health #(
      .RCT_WIN (RCT_WIN),
      .APT_WIN (APT_WIN),
      .RCUT_W  (RCUT_W),
      .ACUT_W  (ACUT_W)
   ) health_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (in_test),
      .bit_i      (noise_bit_i),
      .rct_cut_i  (rct_cutoff_i),
      .apt_cut_i  (apt_cutoff_i),
      .rct_fail_o (rct_fail),
      .apt_fail_o (apt_fail)
   );

   trng_mixer #(
      .MIX_W   (MIX_W),
      .MIX_TAP (MIX_TAP)
   ) mixer_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (mix_run),
      .bit_i     (noise_bit_i),
      .mix_bit_o (mix_bit)
   );

   trng_word_fifo #(
      .WORD_W (WORD_W),
      .DEPTH  (FIFO_DEPTH)
   ) fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (!collecting),
      .bit_vld_i (collecting),
      .bit_i     (fifo_bit),
      .pop_i     (pop),
      .rd_data_o (rd_data_o),
      .empty_o   (fifo_empty)
   );

   assign rd_valid_o = (phase == PH_READY) && !fifo_empty;
   assign pop        = rd_en_i && rd_valid_o;

   always_ff @(posedge clk) begin
      if (!rst_n)
         err_q <= '0;
      else
         err_q <= err_q | {apt_fail, rct_fail};
   end

   assign phase_o      = phase;
   assign health_err_o = err_q;

endmodule

// File: rtl/trng_startup_seq_chk.sv
module trng_startup_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       enable_i,
   input logic       rd_valid_o,
   input logic [2:0] phase_o,
   input logic [1:0] health_err_o
);

   // R1
   phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o <= 3'd5);

   // R2
   start_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 3'd0 && enable_i) |=> phase_o == 3'd1);

   // R3
   test_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 3'd2 && $past(phase_o) != 3'd2) |-> $past(phase_o) == 3'd1);

   // R4
   fill_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 3'd4 && $past(phase_o) != 3'd4)
         |-> ($past(phase_o) == 3'd3 || $past(phase_o) == 3'd2));

   // R5
   valid_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> phase_o == 3'd5);

   // R8
   rct_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      health_err_o[0] |=> health_err_o[0]);

   // R8
   apt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      health_err_o[1] |=> health_err_o[1]);

   // R9
   disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (phase_o == 3'd0 && !rd_valid_o));

endmodule

bind trng_startup_seq trng_startup_seq_chk chk_i (.*);

// File: tb/trng_startup_seq_tb_top.sv
module trng_startup_seq_tb_top;

   localparam int WM = 20;
   localparam int WD = 12;
   localparam int RW = 8;
   localparam int AW = 32;
   localparam int CC = 8;
   localparam int DP = 4;
   localparam int WW = 8;
   localparam int MW = 16;
   localparam int MT = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          nb = 1'b0;
   logic          byp = 1'b0;
   logic [4:0]    wcfg = '0;
   logic [3:0]    rcut = 4'd4;
   logic [5:0]    acut = 6'd24;
   logic          rd_en = 1'b0;
   logic [WW-1:0] rd_data;
   logic          rd_valid;
   logic [2:0]    phase;
   logic [1:0]    err;

   int checks = 0;
   int fails  = 0;
   int mode   = 0;
   int tidx   = 0;
   int nlog   = 0;
   logic [2:0]  ph;
   logic        logb [64];
   logic [2:0]  logp [64];
   logic [15:0] lf = 16'hACE1;
   int len [6];
   int order [8];
   int nord;
   logic [WW-1:0] exp_w [DP];

   always #5 clk = ~clk;

   trng_startup_seq #(
      .WARM_MAX (WM), .WARM_DEF (WD), .RCT_WIN (RW), .APT_WIN (AW),
      .COND_CYC (CC), .FIFO_DEPTH (DP), .WORD_W (WW), .MIX_W (MW), .MIX_TAP (MT)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .enable_i (en), .noise_bit_i (nb),
      .cond_bypass_i (byp), .warm_cfg_i (wcfg), .rct_cutoff_i (rcut),
      .apt_cutoff_i (acut), .rd_en_i (rd_en), .rd_data_o (rd_data),
      .rd_valid_o (rd_valid), .phase_o (phase), .health_err_o (err)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic logic tbit(input int m, input int i);
      case (m)
         1: return 1'b1;
         2: return (i < 4) ? 1'b0 : (i < 12) ? 1'b1 : logic'((i - 12) % 2);
         3: return (i % 4) != 2;
         default: return logic'(i % 2);
      endcase
   endfunction

   // requirement model of the repetition test (R6)
   function automatic int rct_first(input int m, input int cut);
      int run = 0;
      logic last = 1'b0;
      for (int i = 0; i < AW; i++) begin
         logic b = tbit(m, i);
         if (i % RW == 0) run = 1;
         else if (b == last) run++;
         else run = 1;
         last = b;
         if (run > cut) return i;
      end
      return -1;
   endfunction

   // requirement model of the proportion test (R7)
   function automatic int apt_first(input int m, input int cut);
      int cnt = 0;
      logic rf = tbit(m, 0);
      for (int i = 0; i < AW; i++) begin
         if (tbit(m, i) == rf) cnt++;
         if (cnt > cut) return i;
      end
      return -1;
   endfunction

   task automatic adv();
      @(negedge clk);
      ph = phase;
      if (ph == 3'd2) begin
         nb = tbit(mode, tidx);
         tidx++;
      end else begin
         tidx = 0;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         nb = lf[0];
      end
      if ((ph == 3'd3 || ph == 3'd4) && nlog < 64) begin
         logb[nlog] = nb;
         logp[nlog] = ph;
         nlog++;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      en = 1'b0;
      repeat (3) adv();
      rst_n = 1'b1;
      adv();
   endtask

   task automatic run_seq();
      int cur = -1;
      nlog = 0;
      nord = 0;
      for (int k = 0; k < 6; k++) len[k] = 0;
      for (int g = 0; g < 4000; g++) begin
         adv();
         if (int'(ph) != cur) begin
            if (nord < 8) order[nord] = int'(ph);
            nord++;
            cur = int'(ph);
         end
         if (ph <= 3'd5) len[ph]++;
         if (ph == 3'd5) break;
      end
   endtask

   task automatic build_exp(input bit bp);
      logic [MW-1:0] s = '0;
      logic col [DP*WW];
      int k = 0;
      for (int i = 0; i < nlog; i++) begin
         logic o;
         if (bp) o = logb[i];
         else begin
            o = logb[i] ^ s[MW-1] ^ s[MT];
            s = {s[MW-2:0], o};
         end
         if (logp[i] == 3'd4 && k < DP*WW) begin
            col[k] = o;
            k++;
         end
      end
      for (int w = 0; w < DP; w++)
         for (int b = 0; b < WW; b++)
            exp_w[w][WW-1-b] = col[w*WW + b];
   endtask

   task automatic read_words(input string req);
      for (int w = 0; w < DP; w++) begin
         chk(rd_valid == 1'b1, "R12 valid during read", int'(rd_valid), 1);
         chk(rd_data == exp_w[w], req, int'(rd_data), int'(exp_w[w]));
         rd_en = 1'b1;
         adv();
      end
      rd_en = 1'b0;
   endtask

   initial begin
      #1_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int cnt;
      int k;
      // R1 reset state
      rst_n = 1'b0;
      repeat (2) adv();
      chk(phase == 3'd0, "R1 phase in reset", int'(phase), 0);
      chk(rd_valid == 1'b0, "R1 valid in reset", int'(rd_valid), 0);
      chk(err == 2'b00, "R1 err in reset", int'(err), 0);
      rst_n = 1'b1;
      repeat (5) adv();
      chk(phase == 3'd0, "R1 idle while disabled", int'(phase), 0);

      // default run with whitening
      mode = 0; wcfg = 5'd0; byp = 1'b0;
      en = 1'b1;
      run_seq();
      chk(order[0] == 1, "R2 settle first", order[0], 1);
      chk(len[1] == WD, "R2 default settle length", len[1], WD);
      chk(len[2] == AW, "R3 test length", len[2], AW);
      chk(len[3] == CC, "R4 whiten length", len[3], CC);
      chk(len[4] == DP*WW, "R5 fill length", len[4], DP*WW);
      chk(nord == 5 && order[4] == 5, "R5 order ends in ready", nord, 5);
      chk(rd_valid == 1'b1, "R5 valid on first ready", int'(rd_valid), 1);
      chk(err == 2'b00, "R3 clean tests", int'(err), 0);
      build_exp(1'b0);
      read_words("R11 whitened word");
      repeat (2*WW + 2) adv();
      chk(rd_valid == 1'b1, "R12 refill in ready", int'(rd_valid), 1);

      // R9 disable
      en = 1'b0;
      adv();
      chk(phase == 3'd0, "R9 idle after disable", int'(phase), 0);
      chk(rd_valid == 1'b0, "R9 valid after disable", int'(rd_valid), 0);

      // bypass, explicit settle
      wcfg = 5'd5; byp = 1'b1;
      en = 1'b1;
      run_seq();
      chk(len[1] == 5, "R2 explicit settle length", len[1], 5);
      chk(len[3] == 0, "R4 whiten skipped", len[3], 0);
      chk(order[2] == 4, "R4 fill follows test", order[2], 4);
      chk(len[4] == DP*WW, "R5 fill length bypass", len[4], DP*WW);
      build_exp(1'b1);
      read_words("R10 raw word");

      // clamp and abort mid-fill
      en = 1'b0;
      adv();
      wcfg = 5'd31; byp = 1'b0;
      en = 1'b1;
      k = 0;
      while (ph != 3'd4 && k < 500) begin adv(); k++; end
      repeat (3) adv();
      en = 1'b0;
      adv();
      chk(phase == 3'd0, "R9 abort from fill", int'(phase), 0);
      chk(rd_valid == 1'b0, "R9 queue flushed", int'(rd_valid), 0);
      en = 1'b1;
      run_seq();
      chk(order[0] == 1, "R9 restart at settle", order[0], 1);
      chk(len[1] == WM, "R2 clamped settle length", len[1], WM);
      chk(len[2] == AW, "R9 full test after restart", len[2], AW);

      // R6 window restart of the run count
      do_reset();
      mode = 2; rcut = 4'd5; wcfg = 5'd3; byp = 1'b1;
      en = 1'b1;
      run_seq();
      chk(rct_first(2, 5) == -1, "R6 model says pass", rct_first(2, 5), -1);
      chk(len[2] == AW && err == 2'b00, "R6 runs restart per window", len[2], AW);

      // R6/R8 repetition failure
      do_reset();
      mode = 1; rcut = 4'd4; acut = 6'd24; wcfg = 5'd3;
      en = 1'b1;
      k = 0;
      while (ph != 3'd2 && k < 100) begin adv(); k++; end
      cnt = 0;
      while (err == 2'b00 && cnt < 100) begin adv(); cnt++; end
      chk(cnt == rct_first(1, 4) + 1, "R6 repetition fail clock", cnt, rct_first(1, 4) + 1);
      chk(err == 2'b01, "R8 repetition cause bit", int'(err), 1);
      chk(phase == 3'd2, "R8 stays in test", int'(phase), 2);
      mode = 0;
      cnt = 0;
      while (phase == 3'd2 && cnt < 100) begin cnt++; adv(); end
      chk(cnt == AW, "R8 test restarts full length", cnt, AW);
      en = 1'b0;
      adv();
      chk(err == 2'b01, "R8 sticky across disable", int'(err), 1);

      // R7/R8 proportion failure
      do_reset();
      mode = 3; rcut = 4'd4; acut = 6'd20; wcfg = 5'd3;
      en = 1'b1;
      k = 0;
      while (ph != 3'd2 && k < 100) begin adv(); k++; end
      cnt = 0;
      while (err == 2'b00 && cnt < 100) begin adv(); cnt++; end
      chk(cnt == apt_first(3, 20) + 1, "R7 proportion fail clock", cnt, apt_first(3, 20) + 1);
      chk(err == 2'b10, "R8 proportion cause bit", int'(err), 2);
      chk(rd_valid == 1'b0, "R8 no output after fail", int'(rd_valid), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule